// File: doc/BRIEF.md
# Quad Window Comparator Flags

This block watches the results of four digital filter channels and reports when any of them leaves a programmable window. Each channel has its own signed high limit and signed low limit. When a channel presents a new result, marked by its sample-valid strobe, the block compares that result against both limits. A result at or above the high limit raises the channel's high flag. A result at or below the low limit raises its low flag. Each flag is raised only if its own enable bit is set.

Flags are sticky. Software clears them by writing ones to the matching status bits through a clear strobe and mask. A separate failure pulse from an external modulator-failure detector sets a ninth sticky flag. All nine flags are packed into one status word. A single interrupt line is high while any set flag has its enable bit set.

Top module: `quad_window_flags`

## Requirements
- R1: When `sampleValid[c]` is high and `flagEnable[2c]` is set, a filter value greater than or equal to the channel's high limit sets `status[2c]` at the next clock edge. Equality counts as a hit.
- R2: When `sampleValid[c]` is high and `flagEnable[2c+1]` is set, a filter value less than or equal to the channel's low limit sets `status[2c+1]` at the next clock edge. Equality counts as a hit.
- R3: Filter values and limits are 16-bit two's-complement numbers and are compared as signed values (for example, 0x8000 lies below -10, and -5 lies below 100).
- R4: A flag whose enable bit is clear never sets. Setting the enable bit later does not raise the flag for an earlier out-of-window sample.
- R5: With `sampleValid[c]` low, channel c's flags do not change, whatever its filter value and limits.
- R6: A set flag stays set until it is cleared, even after the filter value returns inside the window.
- R7: A cycle with `clrStrobe` high clears, at the next edge, exactly those flags whose `clrMask` bit is 1. Flags whose mask bit is 0 keep their value.
- R8: If a flag is set and cleared in the same cycle, it ends up set.
- R9: The status layout is fixed. For channel index c = 0..3 (channel 1 is c = 0), bit 2c is the high flag and bit 2c+1 is the low flag. Bit 8 is the failure flag, where 1 means failure and 0 means normal operation. `flagEnable` and `clrMask` use the same bit positions.
- R10: A high `failPulse` sets `status[8]` at the next edge, whatever `flagEnable[8]` is. The flag stays set until cleared as in R7.
- R11: `irq` is high in the same cycle whenever any bit is set in both `status` and `flagEnable`, and low otherwise. `flagEnable[8]` gates the failure flag's share of `irq`.
- R12: While `rstN` is low, every flag is cleared, so `status` is 0 and `irq` is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| sampleValid | input | 4 | Per-channel new-result strobe |
| filtData | input | 64 | Filter results, channel c in bits [16c+15:16c], signed |
| hiLimit | input | 64 | High limits, same packing, signed |
| loLimit | input | 64 | Low limits, same packing, signed |
| flagEnable | input | 9 | Per-flag enable, status layout |
| failPulse | input | 1 | Modulator-failure event |
| clrStrobe | input | 1 | Write-one-to-clear strobe |
| clrMask | input | 9 | Flags to clear, status layout |
| status | output | 9 | Packed sticky flags |
| irq | output | 1 | Combined interrupt |

## Verification
A fault in the flag register shows up on `status` one clock after the stimulus that exposes it. Such faults include a bit lost, a bit set without cause, a clear that wins over a set, or a bit in the wrong position. Because `irq` is formed without a register from the stored flags and the enables, a wrong flag also shows on `irq` in that same cycle whenever its enable is set. Comparator faults, such as an unsigned compare or an exclusive boundary, appear only for values at the limits or of opposite sign. The stimulus therefore places filter values exactly on each limit and across zero.

// File: rtl/qwf_pkg.sv
package qwf_pkg;
  parameter int QWF_NUM_CH = 4;
  parameter int QWF_DATA_W = 16;
  localparam int QWF_FLAG_W = 2 * QWF_NUM_CH + 1;

  // Strobes from the comparison datapath to the flag control
  typedef struct packed {
    logic [QWF_FLAG_W-1:0] setMask;
    logic [QWF_FLAG_W-1:0] clrMask;
  } flagStrobes_t;
endpackage

// File: rtl/qwf_datapath.sv
module qwf_datapath
  import qwf_pkg::*;
#(
  parameter int NumCh = QWF_NUM_CH,
  parameter int DataW = QWF_DATA_W
) (
  input  logic [NumCh-1:0]       sampleValid,
  input  logic [NumCh*DataW-1:0] filtData,
  input  logic [NumCh*DataW-1:0] hiLimit,
  input  logic [NumCh*DataW-1:0] loLimit,
  input  logic [2*NumCh:0]       flagEnable,
  input  logic                   failPulse,
  input  logic                   clrStrobe,
  input  logic [2*NumCh:0]       clrMask,
  output flagStrobes_t           strobes
);
  localparam int FlagW = 2 * NumCh + 1;

  logic [FlagW-1:0] setVec;

  for (genvar c = 0; c < NumCh; c++) begin : g_ch
    logic signed [DataW-1:0] sample;
    logic signed [DataW-1:0] hiT;
    logic signed [DataW-1:0] loT;
    logic hiHit;
    logic loHit;

    assign sample = filtData[c*DataW +: DataW];
    assign hiT    = hiLimit[c*DataW +: DataW];
    assign loT    = loLimit[c*DataW +: DataW];
    assign hiHit  = (sample >= hiT);
    assign loHit  = (sample <= loT);

    assign setVec[2*c]   = sampleValid[c] & flagEnable[2*c]   & hiHit;
    assign setVec[2*c+1] = sampleValid[c] & flagEnable[2*c+1] & loHit;
  end

  assign setVec[FlagW-1] = failPulse;

  assign strobes.setMask = setVec;
  assign strobes.clrMask = clrStrobe ? clrMask : '0;
endmodule

// File: rtl/qwf_control.sv
module qwf_control
  import qwf_pkg::*;
#(
  parameter int NumCh = QWF_NUM_CH
) (
  input  logic               clk,
  input  logic               rstN,
  input  flagStrobes_t       strobes,
  input  logic [2*NumCh:0]   flagEnable,
  output logic [2*NumCh:0]   status,
  output logic               irq
);
  localparam int FlagW = 2 * NumCh + 1;

  logic [FlagW-1:0] flagsQ;
  logic [FlagW-1:0] flagsD;

  // A new event in the same cycle outranks a clear
  always_comb begin
    flagsD = (flagsQ & ~strobes.clrMask) | strobes.setMask;
  end

  always_ff @(posedge clk) begin
    if (!rstN) flagsQ <= '0;
    else       flagsQ <= flagsD;
  end

  assign status = flagsQ;
  assign irq    = |(flagsQ & flagEnable);
endmodule

// File: rtl/quad_window_flags.sv
module quad_window_flags
  import qwf_pkg::*;
#(
  parameter int NumCh = QWF_NUM_CH,
  parameter int DataW = QWF_DATA_W
) (
  input  logic                   clk,
  input  logic                   rstN,
  input  logic [NumCh-1:0]       sampleValid,
  input  logic [NumCh*DataW-1:0] filtData,
  input  logic [NumCh*DataW-1:0] hiLimit,
  input  logic [NumCh*DataW-1:0] loLimit,
  input  logic [2*NumCh:0]       flagEnable,
  input  logic                   failPulse,
  input  logic                   clrStrobe,
  input  logic [2*NumCh:0]       clrMask,
  output logic [2*NumCh:0]       status,
  output logic                   irq
);
  flagStrobes_t strobes;

  qwf_datapath #(.NumCh(NumCh), .DataW(DataW)) u_dp (
    .sampleValid(sampleValid),
    .filtData   (filtData),
    .hiLimit    (hiLimit),
    .loLimit    (loLimit),
    .flagEnable (flagEnable),
    .failPulse  (failPulse),
    .clrStrobe  (clrStrobe),
    .clrMask    (clrMask),
    .strobes    (strobes)
  );

  qwf_control #(.NumCh(NumCh)) u_ctl (
    .clk       (clk),
    .rstN      (rstN),
    .strobes   (strobes),
    .flagEnable(flagEnable),
    .status    (status),
    .irq       (irq)
  );
endmodule

// File: rtl/qwf_checker.sv
module qwf_checker #(
  parameter int NumCh = 4,
  parameter int DataW = 16
) (
  input logic                   clk,
  input logic                   rstN,
  input logic [NumCh-1:0]       sampleValid,
  input logic [NumCh*DataW-1:0] filtData,
  input logic [NumCh*DataW-1:0] hiLimit,
  input logic [NumCh*DataW-1:0] loLimit,
  input logic [2*NumCh:0]       flagEnable,
  input logic                   failPulse,
  input logic                   clrStrobe,
  input logic [2*NumCh:0]       clrMask,
  input logic [2*NumCh:0]       status,
  input logic                   irq
);
  localparam int FlagW = 2 * NumCh + 1;

  logic [FlagW-1:0] maySet;

  for (genvar c = 0; c < NumCh; c++) begin : g_chk
    logic signed [DataW-1:0] sample;
    logic signed [DataW-1:0] hiT;
    logic signed [DataW-1:0] loT;
    assign sample = filtData[c*DataW +: DataW];
    assign hiT    = hiLimit[c*DataW +: DataW];
    assign loT    = loLimit[c*DataW +: DataW];
    assign maySet[2*c]   = sampleValid[c] & flagEnable[2*c];
    assign maySet[2*c+1] = sampleValid[c] & flagEnable[2*c+1];

    assert_hi_set_R1: assert property (@(posedge clk) disable iff (!rstN)
      (sampleValid[c] && flagEnable[2*c] && (sample >= hiT)) |=> status[2*c]);
    assert_lo_set_R2: assert property (@(posedge clk) disable iff (!rstN)
      (sampleValid[c] && flagEnable[2*c+1] && (sample <= loT)) |=> status[2*c+1]);
  end
  assign maySet[FlagW-1] = failPulse;

  for (genvar i = 0; i < FlagW; i++) begin : g_bit
    assert_no_cause_R4: assert property (@(posedge clk) disable iff (!rstN)
      (!status[i] && !maySet[i]) |=> !status[i]);
    assert_sticky_R6: assert property (@(posedge clk) disable iff (!rstN)
      (status[i] && !(clrStrobe && clrMask[i])) |=> status[i]);
    assert_clear_R7: assert property (@(posedge clk) disable iff (!rstN)
      (clrStrobe && clrMask[i] && !maySet[i]) |=> !status[i]);
    assert_irq_on_R11: assert property (@(posedge clk) disable iff (!rstN)
      (status[i] && flagEnable[i]) |-> irq);
  end

  assert_fail_set_R10: assert property (@(posedge clk) disable iff (!rstN)
    failPulse |=> status[FlagW-1]);
  assert_irq_cause_R11: assert property (@(posedge clk) disable iff (!rstN)
    irq |-> (status != '0));
endmodule

bind quad_window_flags qwf_checker #(.NumCh(NumCh), .DataW(DataW)) u_chk (.*);

// File: tb/sim_quad_window_flags.sv
`timescale 1ns/1ps
module sim_quad_window_flags;
  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic [3:0]  sampleValid = '0;
  logic [63:0] filtData = '0;
  logic [63:0] hiLimit = '0;
  logic [63:0] loLimit = '0;
  logic [8:0]  flagEnable = '0;
  logic        failPulse = 1'b0;
  logic        clrStrobe = 1'b0;
  logic [8:0]  clrMask = '0;
  logic [8:0]  status;
  logic        irq;

  always #2 clk = ~clk;

  quad_window_flags u0 (.*);

  int testsRun = 0;
  int testsFailed = 0;
  bit finished = 1'b0;

  logic signed [15:0] dataV [4];
  logic signed [15:0] hiV [4];
  logic signed [15:0] loV [4];
  logic [8:0] model = '0;

  logic [9:0] expQ [$];
  string      tagQ [$];

  // Driver: drive one cycle of inputs, predict the result, push it
  task automatic step(input logic [3:0] v, input logic [8:0] en, input logic fp,
                      input logic cs, input logic [8:0] cm, input string tag);
    logic [8:0] setM;
    @(negedge clk);
    for (int c = 0; c < 4; c++) begin
      filtData[16*c +: 16] = dataV[c];
      hiLimit[16*c +: 16]  = hiV[c];
      loLimit[16*c +: 16]  = loV[c];
    end
    sampleValid = v; flagEnable = en; failPulse = fp; clrStrobe = cs; clrMask = cm;
    setM = '0;
    for (int c = 0; c < 4; c++) begin
      if (v[c] && en[2*c]   && dataV[c] >= hiV[c]) setM[2*c]   = 1'b1;
      if (v[c] && en[2*c+1] && dataV[c] <= loV[c]) setM[2*c+1] = 1'b1;
    end
    setM[8] = fp;
    model = (model & ~(cs ? cm : 9'h0)) | setM;
    expQ.push_back({|(model & en), model});
    tagQ.push_back(tag);
  endtask

  // Monitor: compare after each edge
  initial begin
    forever begin
      @(posedge clk);
      #1;
      if (expQ.size() > 0) begin
        logic [9:0] e;
        string t;
        e = expQ.pop_front();
        t = tagQ.pop_front();
        testsRun++;
        if ({irq, status} !== e) begin
          testsFailed++;
          $display("FAIL %s: irq/status actual %b/%b expected %b/%b", t, irq, status, e[9], e[8:0]);
        end
      end
    end
  end

  initial begin
    for (int c = 0; c < 4; c++) begin dataV[c] = 0; hiV[c] = 16'sd1000; loV[c] = -16'sd1000; end
    repeat (3) @(posedge clk);
    #1;
    testsRun++;
    if (status !== 9'h0 || irq !== 1'b0) begin
      testsFailed++;
      $display("FAIL R12: reset status %b irq %b expected 0 0", status, irq);
    end
    @(negedge clk); rstN = 1'b1;

    // R1 inclusive high boundary on channel 1 (bit 0)
    dataV[0] = 16'sd1000;
    step(4'b0001, 9'h1FF, 0, 0, 9'h0, "R1 high equal sets bit0");
    dataV[0] = 16'sd999;
    step(4'b0001, 9'h1FF, 0, 0, 9'h0, "R6 below high keeps bit0");
    step(4'b0000, 9'h1FF, 0, 1, 9'h001, "R7 clear bit0");
    dataV[0] = 16'sd999;
    step(4'b0001, 9'h1FF, 0, 0, 9'h0, "R1 just below high no set");
    // R2 inclusive low boundary, channel 2 layout (bit 3)
    dataV[1] = -16'sd1000;
    step(4'b0010, 9'h1FF, 0, 0, 9'h0, "R2 R9 low equal sets bit3");
    dataV[1] = -16'sd999;
    step(4'b0010, 9'h1FF, 0, 1, 9'h008, "R2 just above low, clear bit3");
    // R3 signed compares on channel 3
    hiV[2] = 16'sd100; loV[2] = -16'sd10; dataV[2] = -16'sd5;
    step(4'b0100, 9'h1FF, 0, 0, 9'h0, "R3 -5 inside window");
    dataV[2] = 16'sh8000;
    step(4'b0100, 9'h1FF, 0, 0, 9'h0, "R3 R9 0x8000 sets low bit5");
    dataV[2] = 16'sh7FFF;
    step(4'b0100, 9'h1FF, 0, 0, 9'h0, "R3 R9 0x7FFF sets high bit4");
    step(4'b0000, 9'h1FF, 0, 1, 9'h030, "R7 clear bits 4,5");
    // R4 disabled flag on channel 4
    dataV[3] = 16'sd2000;
    step(4'b1000, 9'h1BF, 0, 0, 9'h0, "R4 disabled high ch4 no set");
    step(4'b0000, 9'h1FF, 0, 0, 9'h0, "R4 enabling later no retro set");
    // R5 no strobe
    dataV[0] = 16'sh7FFF; dataV[1] = 16'sh8000; dataV[3] = -16'sd2000;
    step(4'b0000, 9'h1FF, 0, 0, 9'h0, "R5 no valid no change");
    // R8 set wins over clear; R9 bit7
    step(4'b1000, 9'h1FF, 0, 1, 9'h080, "R8 R9 set beats clear bit7");
    // R7 selective clear, R11 irq masking
    dataV[0] = 16'sd1000;
    step(4'b0001, 9'h1FF, 0, 0, 9'h0, "R1 set bit0 again");
    step(4'b0000, 9'h1FF, 0, 1, 9'h001, "R7 clear only bit0, bit7 stays");
    step(4'b0000, 9'h07F, 0, 0, 9'h0, "R11 irq off when bit7 disabled");
    // R10 failure flag
    step(4'b0000, 9'h07F, 1, 0, 9'h0, "R10 fail pulse sets bit8 enable off");
    step(4'b0000, 9'h07F, 0, 1, 9'h080, "R11 only fail set and disabled irq low");
    step(4'b0000, 9'h100, 0, 0, 9'h0, "R11 fail enabled irq high");
    step(4'b0000, 9'h100, 0, 0, 9'h0, "R10 fail sticky");
    step(4'b0000, 9'h100, 1, 1, 9'h100, "R8 R10 fail pulse beats clear");
    step(4'b0000, 9'h100, 0, 1, 9'h100, "R10 R7 clear fail bit8");
    // R12 reset mid-run clears flags
    dataV[0] = 16'sd1000;
    step(4'b0001, 9'h1FF, 1, 0, 9'h0, "R1 R10 set before reset");
    @(negedge clk); rstN = 1'b0;
    @(posedge clk); #1;
    testsRun++;
    if (status !== 9'h0 || irq !== 1'b0) begin
      testsFailed++;
      $display("FAIL R12: status %b irq %b expected 0 0", status, irq);
    end
    model = '0;
    @(negedge clk); rstN = 1'b1;
    repeat (3) @(posedge clk);
    #1;
    finished = 1'b1;
    $display("  [TB] %0d tests run, %0d failed", testsRun, testsFailed);
    $finish;
  end

  initial begin
    repeat (5000) @(posedge clk);
    if (!finished) begin
      testsRun++;
      testsFailed++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("  [TB] %0d tests run, %0d failed", testsRun, testsFailed);
      $finish;
    end
  end
endmodule